// File: doc/BRIEF.md
# Multi-Source Event Builder

This block builds one event at a time from several readout sources that share an 8-bit data bus. When a trigger is accepted, it writes a frame header and the current event number. It then visits the sources in ascending index order. For each source it waits until that source reports ready, inserts an identity byte for the source, and grants the bus to that source for a fixed number of cycles. It copies every byte seen on the bus into the frame.

Frames are assembled directly into a byte-wide derandomizing FIFO. A trigger is accepted only when the builder is idle and the FIFO has room for a whole frame. The front end can therefore take new triggers while earlier events are still waiting at the output. The output is a plain valid/ready byte stream. The busy output tells the trigger logic when a trigger would be dropped.

Top module: `evt_assembler`

## Requirements
- R1: Each frame is, in order: the header byte `HDR_BYTE` (0xA5 by default), the event number as a 16-bit value with the high byte first, and then, for each source k from 0 to NSRC-1, the byte `ID_BASE`+k followed by the NBYTES bus bytes of that source in the order they arrived.
- R2: At most one source enable is high in any cycle. Within an event, sources are granted in ascending index order, and each is granted exactly once.
- R3: A grant lasts exactly NBYTES consecutive cycles. Between two grants there is at least one cycle in which no enable is high.
- R4: The grant to source k starts only in the cycle after its request input was sampled high. The builder waits as long as the request stays low.
- R5: The event number is 0 after reset, increases by one for each event built, and wraps at 2^EVN_W.
- R6: busy_o is high while an event is being built, and also whenever the FIFO free space is smaller than one frame. A trigger that arrives while busy_o is high is ignored and produces no frame.
- R7: Complete frames stay in the FIFO while out_ready_i is low. Triggers keep being accepted until the space check fails, and the FIFO never overflows.
- R8: While out_valid_o is high and out_ready_i is low, the next cycle still has out_valid_o high with the same out_data_o. A byte is consumed only on a cycle where out_valid_o and out_ready_i are both high.
- R9: After reset, out_valid_o, busy_o and every source enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger pulse that requests a new event |
| busy_o | output | 1 | High when a trigger would be ignored |
| src_req_i | input | NSRC | Per-source request: the source has its event data ready |
| src_en_o | output | NSRC | Per-source bus grant; the granted source drives bus_i |
| bus_i | input | 8 | Shared source data bus |
| out_data_o | output | 8 | Output stream byte |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream accepts the byte |

## Verification
A wrong state in the sequencer appears at the ports within one frame. It shows up as a misplaced identity byte, a grant of the wrong length, a source visited out of turn, or a header event number that does not match the count of accepted triggers. A wrong FIFO pointer or fill count shows up either as a corrupted or repeated byte the first time the output stalls, or as a busy flag that disagrees with the number of frames held. That number is checked after the output is deliberately starved until it fills. Because the event number is narrow in the test configuration, the count wraps during the run, so an error in the carry at the wrap is also visible.

// File: rtl/evt_assembler.sv
module evt_assembler #(
  parameter int NSRC = 26,
  parameter int NBYTES = 26,
  parameter int EVN_W = 16,
  parameter int DEPTH = 2048,
  parameter logic [7:0] HDR_BYTE = 8'hA5,
  parameter logic [7:0] ID_BASE = 8'h40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_i,
  output logic            busy_o,
  input  logic [NSRC-1:0] src_req_i,
  output logic [NSRC-1:0] src_en_o,
  input  logic [7:0]      bus_i,
  output logic [7:0]      out_data_o,
  output logic            out_valid_o,
  input  logic            out_ready_i
);
  localparam int FRAME = 3 + NSRC * (NBYTES + 1);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int BW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_EVH, S_EVL, S_ID, S_DAT} st_t;

  st_t             st;
  logic [SW-1:0]   sidx;
  logic [BW-1:0]   bidx;
  logic [EVN_W-1:0] evn;
  logic [7:0]      mem [DEPTH];
  logic [AW:0]     wp, rp;
  logic            wr_en;
  logic [7:0]      wr_data;

  wire [AW:0] fill     = wp - rp;
  wire        space_ok = (DEPTH - int'(fill)) >= FRAME;
  wire [15:0] evn16    = 16'(evn);
  wire        last_b   = (bidx == BW'(NBYTES - 1));
  wire        last_s   = (sidx == SW'(NSRC - 1));
  wire        req_sel  = src_req_i[sidx];
  wire        rd_fire  = out_valid_o && out_ready_i;

  assign busy_o      = (st != S_IDLE) || !space_ok;
  assign out_valid_o = (fill != '0);
  assign out_data_o  = mem[rp[AW-1:0]];

  always_comb begin
    wr_en   = 1'b0;
    wr_data = 8'h00;
    case (st)
      S_HDR: begin wr_en = 1'b1; wr_data = HDR_BYTE; end
      S_EVH: begin wr_en = 1'b1; wr_data = evn16[15:8]; end
      S_EVL: begin wr_en = 1'b1; wr_data = evn16[7:0]; end
      S_ID:  begin wr_en = req_sel; wr_data = ID_BASE + 8'(sidx); end
      S_DAT: begin wr_en = 1'b1; wr_data = bus_i; end
      default: ;
    endcase
  end

  always_comb begin
    src_en_o = '0;
    if (st == S_DAT) src_en_o[sidx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      sidx <= '0;
      bidx <= '0;
      evn  <= '0;
    end else begin
      case (st)
        S_IDLE: if (trig_i && space_ok) st <= S_HDR;
        S_HDR:  st <= S_EVH;
        S_EVH:  st <= S_EVL;
        S_EVL:  begin st <= S_ID; sidx <= '0; end
        S_ID:   if (req_sel) begin st <= S_DAT; bidx <= '0; end
        S_DAT: begin
          bidx <= bidx + BW'(1);
          if (last_b) begin
            if (last_s) begin
              st  <= S_IDLE;
              evn <= evn + EVN_W'(1);
            end else begin
              st   <= S_ID;
              sidx <= sidx + SW'(1);
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr_en)   wp <= wp + 1'b1;
      if (rd_fire) rp <= rp + 1'b1;
    end
  end

  assert_onehot_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_en_o));

  assert_grant_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en_o != '0) |=> (src_en_o == '0 || src_en_o == $past(src_en_o)));

  assert_grant_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en_o != '0 && $past(src_en_o) == '0) |-> (($past(src_req_i) & src_en_o) != '0));

  assert_evn_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DAT && last_b && last_s) |=> (evn == $past(evn) + EVN_W'(1)));

  assert_busy_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && trig_i && busy_o) |=> (st == S_IDLE));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(fill) < DEPTH));

  assert_hold_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
endmodule

// File: tb/evt_assembler_bench.sv
module evt_assembler_bench;
  localparam int NS = 3, NB = 4, EW = 4, DP = 64;
  localparam int FR = 3 + NS * (NB + 1);

  logic clk = 0, rst_n = 0, trig = 0, ready = 0;
  logic [NS-1:0] req = '0, en;
  logic [7:0] bus, od;
  logic ov, busy;

  always #4 clk = ~clk;

  evt_assembler #(.NSRC(NS), .NBYTES(NB), .EVN_W(EW), .DEPTH(DP),
                  .HDR_BYTE(8'hA5), .ID_BASE(8'h40)) u_evt_assembler (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .busy_o(busy),
    .src_req_i(req), .src_en_o(en), .bus_i(bus),
    .out_data_o(od), .out_valid_o(ov), .out_ready_i(ready));

  int nchk = 0, nfail = 0, cyc = 0, acc = 0;
  int rmode = 0, smode = 0;

  function automatic logic [7:0] src_byte(int e, int k, int j);
    return 8'(e * 37 + k * 11 + j * 5 + 1);
  endfunction

  function automatic logic [7:0] exp_byte(int e, int pos);
    int q, k, r;
    if (pos == 0) return 8'hA5;
    if (pos == 1) return 8'h00;
    if (pos == 2) return 8'(e % (1 << EW));
    q = pos - 3; k = q / (NB + 1); r = q % (NB + 1);
    if (r == 0) return 8'h40 + 8'(k);
    return src_byte(e, k, r - 1);
  endfunction

  task automatic chk(bit ok, string rq, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    for (int k = 0; k < NS; k++)
      req[k] = (smode == 0) ? 1'b1 : (((cyc + 3 * k) % 4) == 0);
    case (rmode)
      0: ready = 1'b0;
      1: ready = (cyc % 5) != 0;
      default: ready = (cyc % 3) != 0;
    endcase
  end

  int jc [NS];
  int sev [NS];
  always @(posedge clk) begin
    for (int k = 0; k < NS; k++) begin
      if (!rst_n) begin
        jc[k] <= 0; sev[k] <= 0;
      end else if (en[k]) begin
        if (jc[k] == NB - 1) begin jc[k] <= 0; sev[k] <= sev[k] + 1; end
        else jc[k] <= jc[k] + 1;
      end
    end
  end

  always_comb begin
    bus = 8'h00;
    for (int k = 0; k < NS; k++) if (en[k]) bus = src_byte(sev[k], k, jc[k]);
  end

  int frm = 0, pos = 0, glen = 0, lastk = NS - 1;
  bit hold = 0;
  logic [7:0] hd;
  logic [NS-1:0] pen = '0, preq = '0;

  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      if (hold) begin
        chk(ov === 1'b1 && od === hd, "R8 stalled byte held", int'(od), int'(hd));
      end
      hold = ov && !ready;
      hd = od;
      if (ov && ready) begin
        chk(od === exp_byte(frm, pos), "R1 stream byte", int'(od), int'(exp_byte(frm, pos)));
        if (pos == FR - 1) begin pos = 0; frm++; end
        else pos++;
      end
      chk($countones(en) <= 1, "R2 one enable", int'(en), 0);
      for (int k = 0; k < NS; k++)
        if (en[k] && !pen[k])
          chk(preq[k] === 1'b1, "R4 grant after request", int'(preq[k]), 1);
      if (en != '0 && pen != '0)
        chk(en == pen, "R3 idle cycle between grants", int'(en), int'(pen));
      if (en != '0) glen++;
      if (en == '0 && pen != '0) begin
        int k0 = 0;
        for (int k = 0; k < NS; k++) if (pen[k]) k0 = k;
        chk(glen == NB, "R3 grant length", glen, NB);
        chk(k0 == (lastk + 1) % NS, "R2 source order", k0, (lastk + 1) % NS);
        lastk = k0;
        glen = 0;
      end
      pen = en;
      preq = req;
    end
  end

  task automatic pulse(output bit a);
    @(negedge clk);
    trig = 1'b1;
    #3 a = !busy;
    if (a) acc++;
    @(negedge clk);
    trig = 1'b0;
  endtask

  initial begin
    bit a, b;
    int got;
    repeat (3) @(negedge clk);
    #3;
    chk(ov == 1'b0, "R9 reset valid", int'(ov), 0);
    chk(busy == 1'b0, "R9 reset busy", int'(busy), 0);
    chk(en == '0, "R9 reset enables", int'(en), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk(ov == 1'b0 && busy == 1'b0 && en == '0, "R9 after release", int'({ov, busy}), 0);

    rmode = 1; smode = 1;
    for (int i = 0; i < 20; i++) begin
      pulse(a);
      chk(a, "R6 trigger accepted when idle", int'(a), 1);
      pulse(b);
      chk(!b, "R6 trigger ignored while building", int'(b), 0);
      repeat (60) @(negedge clk);
    end
    chk(frm == 20, "R5 frames through wrap", frm, 20);

    rmode = 0;
    repeat (50) @(negedge clk);
    got = 0;
    for (int i = 0; i < 5; i++) begin
      pulse(a);
      if (a) got++;
      repeat (60) @(negedge clk);
    end
    #3;
    chk(got == 3, "R7 frames buffered while output stalled", got, 3);
    chk(busy == 1'b1, "R6 busy when free space short", int'(busy), 1);
    chk(ov == 1'b1 && frm == 20, "R7 frames held", frm, 20);
    pulse(a);
    chk(!a, "R6 trigger ignored when full", int'(a), 0);

    smode = 0; rmode = 2;
    repeat (300) @(negedge clk);
    #3;
    chk(frm == acc, "R6 frame count equals accepted triggers", frm, acc);
    chk(busy == 1'b0 && ov == 1'b0, "R7 drained", int'({busy, ov}), 0);

    for (int i = 0; i < 3; i++) begin
      pulse(a);
      chk(a, "R5 accept after drain", int'(a), 1);
      repeat (40) @(negedge clk);
    end
    #3;
    chk(frm == acc, "R5 final frame count", frm, acc);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule